// File: doc/BRIEF.md
# Symbol-to-MLT-3 Transmit Encoder

This block turns a stream of 5-bit scrambled line symbols into a three-level line code. A symbol is captured on each rising edge of a symbol clock. On the next cycle of a bit clock running five times faster, the symbol is moved into a shift register. The shift register sends the symbol out most significant bit first. Each serial bit goes through an NRZI stage and then an MLT-3 stage. The result is a 2-bit signed level code that tells an analog driver what to put on the differential pair.

Three active controls gate the output. A speed select and a power-down input turn the whole path off: both outputs go to zero and the encoder state is cleared. An active-low loopback input takes the level off the line output and sends it to a separate loopback port that feeds the receive side. Both clocks come from one source and their rising edges are aligned, with one symbol edge on every fifth bit edge.

Top module: `mlt3_tx_encoder`

## Requirements
- R1: The value on `sym_in` is captured on every rising edge of `sym_clk`, one symbol for each symbol clock.
- R2: A captured symbol is loaded into the shift register on the first `bit_clk` edge after the capture. Its five bits are then used on the next five `bit_clk` edges, bit 4 first and bit 0 last. When no new symbol is waiting, the serial stream is 0.
- R3: The NRZI stage toggles its state for each serial 1 and holds its state for each serial 0.
- R4: Each NRZI transition moves the MLT-3 level one step through the cycle 0, +1, 0, -1. With no transition the level stays where it is. After a clear, the cycle starts again from the first 0.
- R5: Level codes are 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. The code 2'b10 never appears.
- R6: While `spd_sel` is low, both `line_lvl` and `loop_lvl` are 2'b00 and the encoder state is cleared. When `spd_sel` goes high again, the level is still 0.
- R7: While `pwr_n` is low, both outputs are 2'b00 and the encoder state is cleared. After `pwr_n` is released, encoding starts again from level 0.
- R8: While `lpbk_n` is low and the path is enabled, `line_lvl` is 2'b00 and `loop_lvl` carries the encoded level. While `lpbk_n` is high, `loop_lvl` is 2'b00 and `line_lvl` carries the encoded level.
- R9: After reset, both outputs are 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock, five times the symbol rate |
| sym_clk | input | 1 | Symbol clock, rising edges aligned with every fifth `bit_clk` rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | SYM_W | Parallel line symbol, captured on `sym_clk` rise |
| spd_sel | input | 1 | High enables the fast transmit path; low disables it |
| lpbk_n | input | 1 | Low sends the encoded level to the loopback port |
| pwr_n | input | 1 | Low powers the path down |
| line_lvl | output | 2 | Level code for the line driver |
| loop_lvl | output | 2 | Level code for the receive-side loopback |

## Verification
The bench sweeps all 32 symbol values back to back. It also sends runs of all ones, all zeros and alternating bits. For each bit edge it works out the expected level from the running count of 1 bits. If the bit order were reversed, a symbol were loaded one cycle late, or the MLT-3 cycle skipped its middle zero, the level would drift from the expected sequence within the first symbols. The bench ends an all-ones run at level -1 and then powers the path down or drops the speed select. A design that did not clear its phase would then restart from -1 or +1 instead of 0. Loopback runs check that the level appears on only one of the two ports.

// File: rtl/mlt_tx_pkg.sv
package mlt_tx_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_ZERO = 2'b00;
    localparam lvl_t LVL_POS  = 2'b01;
    localparam lvl_t LVL_NEG  = 2'b11;

    // Four-step MLT-3 phase: 0 -> +1 -> 0 -> -1
    function automatic lvl_t phase_to_lvl(input logic [1:0] ph);
        case (ph)
            2'd1:    return LVL_POS;
            2'd3:    return LVL_NEG;
            default: return LVL_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/tx_sym_capture.sv
module tx_sym_capture #(
    parameter int SYM_W = 5
) (
    input  logic             sym_clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] sym_in,
    output logic [SYM_W-1:0] cap_sym,
    output logic             cap_tog
);

    typedef struct packed {
        logic [SYM_W-1:0] sym;
        logic             tog;
    } cap_st_t;

    cap_st_t st_d, st_q;

    // R1: take one symbol per symbol clock, flag it with a toggle
    always_comb begin
        st_d     = st_q;
        st_d.sym = sym_in;
        st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge sym_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_sym = st_q.sym;
    assign cap_tog = st_q.tog;

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
    parameter int SYM_W = 5
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SYM_W-1:0] cap_sym,
    input  logic             cap_tog,
    output logic             ser_bit
);

    localparam int MSB = SYM_W - 1;

    typedef struct packed {
        logic [SYM_W-1:0] sr;
        logic             tog;
    } ser_st_t;

    ser_st_t st_d, st_q;

    // R2: a changed capture toggle means a fresh symbol is waiting
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.sr  = '0;
            st_d.tog = cap_tog;
        end else if (cap_tog != st_q.tog) begin
            st_d.sr  = cap_sym;
            st_d.tog = cap_tog;
        end else begin
            st_d.sr  = {st_q.sr[MSB-1:0], 1'b0};
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_bit = st_q.sr[MSB];

endmodule

// File: rtl/tx_line_coder.sv
module tx_line_coder
    import mlt_tx_pkg::*;
(
    input  logic bit_clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ser_bit,
    output lvl_t lvl
);

    typedef struct packed {
        logic       nrzi;
        logic [1:0] phase;
    } cod_st_t;

    cod_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            // R3: a 1 flips the NRZI state
            st_d.nrzi = st_q.nrzi ^ ser_bit;
            // R4: each NRZI edge advances the MLT-3 phase
            if (st_d.nrzi != st_q.nrzi)
                st_d.phase = st_q.phase + 2'd1;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    assign lvl = phase_to_lvl(st_q.phase);

endmodule

// File: rtl/mlt3_tx_encoder.sv
module mlt3_tx_encoder
    import mlt_tx_pkg::*;
#(
    parameter int SYM_W = 5
) (
    input  logic             bit_clk,
    input  logic             sym_clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] sym_in,
    input  logic             spd_sel,
    input  logic             lpbk_n,
    input  logic             pwr_n,
    output logic [1:0]       line_lvl,
    output logic [1:0]       loop_lvl
);

    logic [SYM_W-1:0] cap_sym;
    logic             cap_tog;
    logic             ser_bit;
    logic             path_on;
    lvl_t             enc_lvl;

    // R6, R7: the path runs only when fast mode is on and it is powered
    assign path_on = spd_sel & pwr_n;

    tx_sym_capture #(.SYM_W(SYM_W)) u_cap (
        .sym_clk (sym_clk),
        .rst_n   (rst_n),
        .sym_in  (sym_in),
        .cap_sym (cap_sym),
        .cap_tog (cap_tog)
    );

    tx_serializer #(.SYM_W(SYM_W)) u_ser (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .clr     (~path_on),
        .cap_sym (cap_sym),
        .cap_tog (cap_tog),
        .ser_bit (ser_bit)
    );

    tx_line_coder u_cod (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .clr     (~path_on),
        .ser_bit (ser_bit),
        .lvl     (enc_lvl)
    );

    // R8: steer the level to the line or to the loopback port
    always_comb begin
        line_lvl = LVL_ZERO;
        loop_lvl = LVL_ZERO;
        if (path_on) begin
            if (lpbk_n) line_lvl = enc_lvl;
            else        loop_lvl = enc_lvl;
        end
    end

endmodule

// File: rtl/mlt_tx_chk.sv
module mlt_tx_chk (
    input logic       bit_clk,
    input logic       rst_n,
    input logic       spd_sel,
    input logic       lpbk_n,
    input logic       pwr_n,
    input logic [1:0] line_lvl,
    input logic [1:0] loop_lvl
);

    logic live;
    assign live = spd_sel & pwr_n & lpbk_n;

    // R5
    code_legal_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (line_lvl != 2'b10) && (loop_lvl != 2'b10));

    // R4
    no_pos_to_neg_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (live && $past(live) && $past(line_lvl) == 2'b01) |-> line_lvl != 2'b11);

    // R4
    no_neg_to_pos_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (live && $past(live) && $past(line_lvl) == 2'b11) |-> line_lvl != 2'b01);

    // R8
    one_port_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !((line_lvl != 2'b00) && (loop_lvl != 2'b00)));

    // R7
    pwr_clear_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $past(!pwr_n) |-> (line_lvl == 2'b00 && loop_lvl == 2'b00));

    // R6
    spd_clear_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $past(!spd_sel) |-> (line_lvl == 2'b00 && loop_lvl == 2'b00));

endmodule

bind mlt3_tx_encoder mlt_tx_chk u_chk (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .spd_sel  (spd_sel),
    .lpbk_n   (lpbk_n),
    .pwr_n    (pwr_n),
    .line_lvl (line_lvl),
    .loop_lvl (loop_lvl)
);

// File: tb/tb_mlt3_tx_encoder.sv
module tb_mlt3_tx_encoder;

    localparam int BIT_PERIOD = 8;
    localparam int SYM_W      = 5;

    logic             bit_clk = 1'b0;
    logic             sym_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic [SYM_W-1:0] sym_in  = '0;
    logic             spd_sel = 1'b1;
    logic             lpbk_n  = 1'b1;
    logic             pwr_n   = 1'b0;
    logic [1:0]       line_lvl;
    logic [1:0]       loop_lvl;

    int n_checks = 0;
    int n_fails  = 0;

    mlt3_tx_encoder #(.SYM_W(SYM_W)) dut (
        .bit_clk  (bit_clk),
        .sym_clk  (sym_clk),
        .rst_n    (rst_n),
        .sym_in   (sym_in),
        .spd_sel  (spd_sel),
        .lpbk_n   (lpbk_n),
        .pwr_n    (pwr_n),
        .line_lvl (line_lvl),
        .loop_lvl (loop_lvl)
    );

    // symbol clock rises together with every fifth bit clock rise
    initial begin
        int ph = 0;
        forever begin
            #(BIT_PERIOD / 2);
            bit_clk = 1'b1;
            sym_clk = (ph < 3);
            ph = (ph + 1) % 5;
            #(BIT_PERIOD / 2);
            bit_clk = 1'b0;
        end
    end

    function automatic logic [1:0] lvl_of(input int ones);
        case (ones % 4)
            1:       return 2'b01;
            3:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [SYM_W-1:0] sym_of(input int mode, input int i);
        case (mode)
            0:       return SYM_W'(i % 32);
            1:       return 5'h1F;
            2:       return 5'h00;
            default: return (i % 2 == 0) ? 5'h15 : 5'h0A;
        endcase
    endfunction

    task automatic check2(input string req, input logic [1:0] act_line,
                          input logic [1:0] exp_line, input logic [1:0] act_loop,
                          input logic [1:0] exp_loop);
        n_checks++;
        if (act_line !== exp_line || act_loop !== exp_loop) begin
            n_fails++;
            $display("FAIL %s line=%b loop=%b expected line=%b loop=%b",
                     req, act_line, act_loop, exp_line, exp_loop);
        end
    endtask

    // R1 R2 R3 R4 R5 R8: stream symbols and compare every bit period
    task automatic run_burst(input int nsym, input int mode, input logic spd,
                             input logic lpb, input string req);
        int ones = 0;
        int total = nsym * SYM_W;
        pwr_n   = 1'b0;
        spd_sel = spd;
        lpbk_n  = lpb;
        repeat (3) @(negedge bit_clk);
        @(posedge sym_clk);
        @(posedge bit_clk);
        @(negedge bit_clk);
        pwr_n  = 1'b1;
        sym_in = sym_of(mode, 0);
        @(posedge sym_clk);
        for (int k = 0; k < total + 3; k++) begin
            logic [SYM_W-1:0] s;
            logic [1:0] e;
            @(negedge bit_clk);
            if (k % SYM_W == 0)
                sym_in = (k / SYM_W + 1 < nsym) ? sym_of(mode, k / SYM_W + 1) : '0;
            if (k >= 2 && k - 2 < total) begin
                s = sym_of(mode, (k - 2) / SYM_W);
                ones += int'(s[SYM_W - 1 - ((k - 2) % SYM_W)]);
            end
            e = spd ? lvl_of(ones) : 2'b00;
            check2(req, line_lvl, lpb ? e : 2'b00, loop_lvl, lpb ? 2'b00 : e);
        end
    endtask

    initial begin
        #(BIT_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge bit_clk);
        // R9
        check2("R9 reset", line_lvl, 2'b00, loop_lvl, 2'b00);
        rst_n = 1'b1;
        repeat (2) @(negedge bit_clk);
        check2("R9 after reset", line_lvl, 2'b00, loop_lvl, 2'b00);

        run_burst(32, 0, 1'b1, 1'b1, "R2 R4 sweep all symbols");
        run_burst(6,  3, 1'b1, 1'b1, "R2 alternating bits");
        run_burst(4,  2, 1'b1, 1'b1, "R3 all zeros hold");

        // 15 ones leave the level at -1, then power down
        run_burst(3,  1, 1'b1, 1'b1, "R3 R4 all ones");
        check2("R7 before power-down", line_lvl, 2'b11, loop_lvl, 2'b00);
        pwr_n = 1'b0;
        #1;
        check2("R7 power-down output", line_lvl, 2'b00, loop_lvl, 2'b00);
        run_burst(2,  1, 1'b1, 1'b1, "R7 restart from zero");

        // 10 ones leave the level at 0 after +1 .. ; use 7 symbols: 35 ones -> -1
        run_burst(7,  1, 1'b1, 1'b1, "R4 long ones");
        check2("R6 before speed drop", line_lvl, 2'b11, loop_lvl, 2'b00);
        spd_sel = 1'b0;
        #1;
        check2("R6 speed low output", line_lvl, 2'b00, loop_lvl, 2'b00);
        repeat (3) @(negedge bit_clk);
        spd_sel = 1'b1;
        #1;
        check2("R6 state cleared", line_lvl, 2'b00, loop_lvl, 2'b00);
        repeat (4) begin
            @(negedge bit_clk);
            check2("R6 stays zero", line_lvl, 2'b00, loop_lvl, 2'b00);
        end

        run_burst(8,  0, 1'b0, 1'b1, "R6 speed low burst");
        run_burst(32, 0, 1'b1, 1'b0, "R8 loopback sweep");
        run_burst(3,  1, 1'b1, 1'b0, "R8 loopback ones");
        check2("R8 loopback end", line_lvl, 2'b00, loop_lvl, 2'b11);
        lpbk_n = 1'b1;
        #1;
        check2("R8 back to line", line_lvl, 2'b11, loop_lvl, 2'b00);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule